// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block converts one synchronous polarity command into the four gate enables of an N-channel H-bridge. The bridge has two legs, A and B, and each leg has an upper switch and a lower switch. The command drives the two diagonal pairs in opposite phase. The design never lets the upper and lower switch of one leg conduct together.

Turn-on of an upper switch waits for an 8-bit upper dead-time count. Turn-on of a lower switch waits for a separate lower dead-time count. Every turn-off happens on the next clock edge, with no added wait.

An upper-switch enable masks both upper gates, so the bridge can chop using the lower switches only. A disable input and an undervoltage flag each force the whole bridge off and clear any turn-on that is in progress.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all four gate outputs are low.
- R2: With `cmd_i`=1 and no override active, `gate_ah_o` and `gate_bl_o` are requested on, and `gate_al_o` and `gate_bh_o` are low.
- R3: With `cmd_i`=0 and no override active, `gate_al_o` and `gate_bh_o` are requested on, and `gate_ah_o` and `gate_bl_o` are low.
- R4: One clock edge after `dis_i` is sampled high, all four outputs are low. This holds whatever the other inputs are.
- R5: One clock edge after `uv_i` is sampled high, all four outputs are low. This holds whatever the other inputs are.
- R6: While `hs_en_i` is low, both upper outputs are low one edge later, and the lower outputs still follow `cmd_i`.
- R7: A gate whose request is first sampled high at edge k rises after edge k+D. D is `hs_dly_i` for the upper gates (A-high, B-high) and `ls_dly_i` for the lower gates. D=0 turns the gate on at edge k.
- R8: A gate whose request is sampled low at an edge is low after that same edge.
- R9: If a request falls before its dead time has elapsed, the gate never rises. A later request starts the full dead time again.
- R10: The dead-time value is sampled at edge k only. Changes to the delay input during the count have no effect on that turn-on.
- R11: `gate_ah_o` and `gate_al_o` are never high in the same cycle, and neither are `gate_bh_o` and `gate_bl_o`. This holds for every delay setting, including zero.
- R12: After disable or undervoltage is released, the next turn-on still waits its full dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 1 | Polarity command; 1 selects the A-high/B-low diagonal |
| hs_en_i | input | 1 | Upper-switch enable; low masks both upper gates |
| dis_i | input | 1 | Disable; high turns all gates off |
| uv_i | input | 1 | Undervoltage flag; high turns all gates off |
| hs_dly_i | input | 8 | Upper-switch turn-on dead time, in cycles |
| ls_dly_i | input | 8 | Lower-switch turn-on dead time, in cycles |
| gate_ah_o | output | 1 | A leg upper gate enable |
| gate_al_o | output | 1 | A leg lower gate enable |
| gate_bh_o | output | 1 | B leg upper gate enable |
| gate_bl_o | output | 1 | B leg lower gate enable |

## Verification
The properties assume that all inputs are synchronous to `clk`. They also assume the inputs settle between edges, so that every override and command is seen as one sampled value per edge. The stimulus changes inputs only on falling edges. It includes command reversals on every cycle with zero dead time, which is the hardest case for leg overlap. It also includes overrides that arrive mid-count and delay changes during a count.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

    localparam int DLY_W = 8;
    localparam int N_GATES = 4;

    // Gate index order; the channel generate loop relies on it.
    localparam int G_AH = 0;
    localparam int G_AL = 1;
    localparam int G_BH = 2;
    localparam int G_BL = 3;

    typedef struct packed {
        logic ah;
        logic al;
        logic bh;
        logic bl;
    } gate_set_t;

    function automatic logic is_upper(input int idx);
        return (idx == G_AH) || (idx == G_BH);
    endfunction

    function automatic logic pick(input gate_set_t s, input int idx);
        case (idx)
            G_AH:    return s.ah;
            G_AL:    return s.al;
            G_BH:    return s.bh;
            default: return s.bl;
        endcase
    endfunction

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
    import hbridge_pkg::*;
(
    input  logic      cmd,
    input  logic      hs_en,
    input  logic      dis,
    input  logic      uv,
    output gate_set_t req
);
    logic run;

    always_comb begin
        run    = !dis && !uv;
        req.ah = run && hs_en && cmd;
        req.bl = run && cmd;
        req.al = run && !cmd;
        req.bh = run && hs_en && !cmd;
    end
endmodule

// File: rtl/hb_deadtime_ch.sv
module hb_deadtime_ch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] dly,
    output logic         gate
);
    logic         busy;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            gate <= 1'b0;
        end else if (!req) begin
            busy <= 1'b0;
            cnt  <= '0;
            gate <= 1'b0;
        end else if (!gate && !busy) begin
            if (dly == '0) begin
                gate <= 1'b1;
            end else begin
                busy <= 1'b1;
                cnt  <= dly;
            end
        end else if (busy) begin
            if (cnt == W'(1)) begin
                busy <= 1'b0;
                cnt  <= '0;
                gate <= 1'b1;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end
endmodule

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl
    import hbridge_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_i,
    input  logic          hs_en_i,
    input  logic          dis_i,
    input  logic          uv_i,
    input  logic [DW-1:0] hs_dly_i,
    input  logic [DW-1:0] ls_dly_i,
    output logic          gate_ah_o,
    output logic          gate_al_o,
    output logic          gate_bh_o,
    output logic          gate_bl_o
);
    gate_set_t          req;
    logic [N_GATES-1:0] gate_v;

    hb_cmd_decode u_dec (
        .cmd   (cmd_i),
        .hs_en (hs_en_i),
        .dis   (dis_i),
        .uv    (uv_i),
        .req   (req)
    );

    for (genvar i = 0; i < N_GATES; i++) begin : g_ch
        logic [DW-1:0] dly_sel;
        assign dly_sel = is_upper(i) ? hs_dly_i : ls_dly_i;

        hb_deadtime_ch #(.W(DW)) u_ch (
            .clk  (clk),
            .rst  (rst),
            .req  (pick(req, i)),
            .dly  (dly_sel),
            .gate (gate_v[i])
        );
    end

    assign gate_ah_o = gate_v[G_AH];
    assign gate_al_o = gate_v[G_AL];
    assign gate_bh_o = gate_v[G_BH];
    assign gate_bl_o = gate_v[G_BL];
endmodule

// File: rtl/hbridge_gate_chk.sv
module hbridge_gate_chk (
    input logic clk,
    input logic rst,
    input logic cmd_i,
    input logic hs_en_i,
    input logic dis_i,
    input logic uv_i,
    input logic gate_ah_o,
    input logic gate_al_o,
    input logic gate_bh_o,
    input logic gate_bl_o
);
    p_leg_a_r11: assert property (@(posedge clk) disable iff (rst)
        !(gate_ah_o && gate_al_o));

    p_leg_b_r11: assert property (@(posedge clk) disable iff (rst)
        !(gate_bh_o && gate_bl_o));

    p_dis_off_r4: assert property (@(posedge clk) disable iff (rst)
        dis_i |=> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));

    p_uv_off_r5: assert property (@(posedge clk) disable iff (rst)
        uv_i |=> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));

    p_hs_mask_r6: assert property (@(posedge clk) disable iff (rst)
        !hs_en_i |=> !(gate_ah_o || gate_bh_o));

    p_off_cmd1_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_i |=> !(gate_al_o || gate_bh_o));

    p_off_cmd0_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_i |=> !(gate_ah_o || gate_bl_o));
endmodule

bind hbridge_gate_ctl hbridge_gate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd_i),
    .hs_en_i   (hs_en_i),
    .dis_i     (dis_i),
    .uv_i      (uv_i),
    .gate_ah_o (gate_ah_o),
    .gate_al_o (gate_al_o),
    .gate_bh_o (gate_bh_o),
    .gate_bl_o (gate_bl_o)
);

// File: tb/hbridge_gate_ctl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd = 1'b0, hs_en = 1'b1, dis = 1'b0, uv = 1'b0;
    logic [7:0] hs_dly = 8'd0, ls_dly = 8'd0;
    logic       ah, al, bh, bl;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // Behavioural model state: cycles each request has been continuously high,
    // the delay captured at its start, and the expected gate value.
    int   run_len [4];
    int   held_dly[4];
    logic exp_g   [4];

    always #5 clk = ~clk;

    hbridge_gate_ctl uut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .hs_en_i(hs_en), .dis_i(dis),
        .uv_i(uv), .hs_dly_i(hs_dly), .ls_dly_i(ls_dly),
        .gate_ah_o(ah), .gate_al_o(al), .gate_bh_o(bh), .gate_bl_o(bl)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    function automatic logic want(input int i);
        logic run;
        run = !dis && !uv;
        case (i)
            0:       return run && hs_en && cmd;
            1:       return run && !cmd;
            2:       return run && hs_en && !cmd;
            default: return run && cmd;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < 4; i++) begin
            if (rst || !want(i)) begin
                run_len[i] = 0;
                exp_g[i]   = 1'b0;
            end else begin
                if (run_len[i] == 0) held_dly[i] = (i == 0 || i == 2) ? int'(hs_dly) : int'(ls_dly);
                run_len[i] = run_len[i] + 1;
                exp_g[i]   = (run_len[i] - 1) >= held_dly[i];
            end
        end
        #2;
        check(cur_req, ah, exp_g[0], "gate_ah");
        check(cur_req, al, exp_g[1], "gate_al");
        check(cur_req, bh, exp_g[2], "gate_bh");
        check(cur_req, bl, exp_g[3], "gate_bl");
        check("R11", ah && al, 1'b0, "leg A overlap");
        check("R11", bh && bl, 1'b0, "leg B overlap");
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            run_len[i] = 0; held_dly[i] = 0; exp_g[i] = 1'b0;
        end
        @(negedge clk);
        cur_req = "R1"; rst = 1'b1; cmd = 1'b1; run(3);
        rst = 1'b0; run(1);
        cur_req = "R2"; hs_dly = 8'd3; ls_dly = 8'd2; run(8);
        cur_req = "R3"; cmd = 1'b0; run(8);
        cur_req = "R7";
        hs_dly = 8'd0; ls_dly = 8'd0;
        for (int k = 0; k < 6; k++) begin cmd = ~cmd; run(1); end
        for (int k = 0; k < 4; k++) begin cmd = ~cmd; run(3); end
        hs_dly = 8'd1; ls_dly = 8'd6;
        for (int k = 0; k < 3; k++) begin cmd = ~cmd; run(9); end
        cur_req = "R8"; hs_dly = 8'd0; ls_dly = 8'd0; cmd = 1'b1; run(3); cmd = 1'b0; run(2);
        cur_req = "R9"; hs_dly = 8'd5; cmd = 1'b1; run(3); cmd = 1'b0; run(1); cmd = 1'b1; run(8);
        cur_req = "R10"; cmd = 1'b0; run(1); hs_dly = 8'd4; cmd = 1'b1; run(1);
        hs_dly = 8'd20; run(2); hs_dly = 8'd1; run(4);
        cur_req = "R6"; hs_dly = 8'd2; ls_dly = 8'd1; hs_en = 1'b0;
        for (int k = 0; k < 3; k++) begin cmd = ~cmd; run(4); end
        hs_en = 1'b1; run(5);
        cur_req = "R4"; cmd = 1'b0; hs_dly = 8'd3; run(2); dis = 1'b1; run(2);
        cmd = 1'b1; run(3); hs_dly = 8'd0; run(2);
        cur_req = "R12"; hs_dly = 8'd4; ls_dly = 8'd3; dis = 1'b0; run(8);
        cur_req = "R5"; uv = 1'b1; run(3); cmd = 1'b0; run(2);
        cur_req = "R12"; uv = 1'b0; run(6);
        cur_req = "R11";
        for (int k = 0; k < 400; k++) begin
            cmd    = 1'($urandom);
            hs_en  = ($urandom % 8) != 0;
            dis    = ($urandom % 16) == 0;
            uv     = ($urandom % 20) == 0;
            hs_dly = 8'($urandom % 4);
            ls_dly = 8'($urandom % 4);
            run(1 + $urandom % 4);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule